// File: doc/BRIEF.md
# Video Memory Host Access Port

This block is the processor-facing side of a video controller that owns a private byte memory. The processor never addresses that memory directly. It talks to four byte-wide ports on its 16-bit bus, and only the upper byte lane of the bus is connected. One write port takes command bytes in pairs. A pair either loads the 14-bit access pointer, tagged for reading or for writing, or writes one of eight configuration registers. A second write port stores a byte at the pointer. One read port returns the byte fetched ahead from the pointer. The other read port returns the status byte. After every data access the pointer advances by one. The processor cannot read the pointer back.

The display engine has priority on the memory. While `engine_busy` is high, any access that would touch the memory is held off through `cpu_ready`. Accesses to status and configuration do not wait. A one-cycle `frame_end` pulse from the display side sets the frame flag. The flag drives the `irq` output. Reading status clears the flag and also restarts the command byte pairing. The eight configuration registers are write-only to the processor and are presented on `ctrl_regs` for the display logic. The pointer spans 16 KB. The storage holds `2**MEM_AW` bytes, so pointer values alias onto it modulo that size.

Top module: `vhp_host_port`

## Requirements
- R1: After reset the pointer, the command phase, the fetch-ahead byte, all eight configuration registers and the frame flag are zero, `irq` is low and a status read returns 0x00.
- R2: A command pair with bits 7:6 of the second byte equal to 01 loads the pointer with {second[5:0], first}. Each accepted write to 0x8C00 stores `cpu_wdata[15:8]` at the pointer (memory index = pointer modulo 2**MEM_AW), then advances the pointer by one.
- R3: A command pair with bits 7:6 of the second byte equal to 00 loads {second[5:0], first}, fetches the byte there and leaves the pointer one past it. Each read of 0x8800 returns the fetched byte on `cpu_rdata[15:8]`, fetches the byte at the pointer and advances the pointer.
- R4: A command pair with bits 7:6 of the second byte equal to 10 writes the first byte into configuration register second[2:0], shown on `ctrl_regs[8*k +: 8]`. The pointer does not change.
- R5: A read of 0x8802 returns the frame flag in bit 15 with bits 14:8 zero. In the next cycle the flag is clear, `irq` is low and the next command byte is treated as a first byte.
- R6: A `frame_end` pulse sets the frame flag and `irq` from the next cycle. If it coincides with a status read, the read returns the old flag and the flag stays set.
- R7: With `engine_busy` high, reads of 0x8800, writes of 0x8C00 and read-address second command bytes hold `cpu_ready` low and change nothing until `engine_busy` falls. Status reads, first command bytes and other second command bytes complete at once.
- R8: `cpu_wdata[7:0]` has no effect and `cpu_rdata[7:0]` is always zero.
- R9: The pointer wraps from 0x3FFF to 0x0000.
- R10: A second command byte with bits 7:6 equal to 11 changes neither the pointer nor any register, and it ends the pair.
- R11: Requests at any address other than the four ports, or with the wrong direction, change nothing and return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Bus request, held until accepted |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 16 | Write data; only [15:8] is used |
| cpu_rdata | output | 16 | Read data on [15:8], [7:0] zero |
| cpu_ready | output | 1 | Low while a memory access waits for the engine |
| engine_busy | input | 1 | Display engine owns the memory |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Frame interrupt request, equal to the frame flag |
| ctrl_regs | output | 64 | Eight configuration bytes, register k at [8k+7:8k] |

## Verification
A status read and a `frame_end` pulse can land in the same cycle. The bench provokes this by raising the pulse in the cycle that accepts a status read, once with the flag clear and once with it already set. The returned byte must show the flag as it stood before that edge, and `irq` must stay high afterwards. A second overlap is a memory access arriving while the engine is busy. The bench holds `engine_busy` across several cycles of a pending data read, data write and read-address command, and checks that `cpu_ready` stays low and that the later data matches a model that saw the access only once.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

    typedef enum logic [1:0] {
        OP_SET_RD = 2'b00,
        OP_SET_WR = 2'b01,
        OP_REG_WR = 2'b10,
        OP_NONE   = 2'b11
    } cmd_op_e;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_DATA,
        ACC_RD_STAT,
        ACC_WR_DATA,
        ACC_WR_CMD
    } acc_e;

endpackage

// File: rtl/vhp_port_decode.sv
module vhp_port_decode
    import vhp_pkg::*;
#(
    parameter int          AW           = 16,
    parameter logic [15:0] RD_DATA_ADDR = 16'h8800,
    parameter logic [15:0] RD_STAT_ADDR = 16'h8802,
    parameter logic [15:0] WR_DATA_ADDR = 16'h8C00,
    parameter logic [15:0] WR_CMD_ADDR  = 16'h8C02
) (
    input  logic          cpu_req,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    output acc_e          acc
);

    always_comb begin
        acc = ACC_IDLE;
        if (cpu_req) begin
            if (!cpu_wr && cpu_addr == AW'(RD_DATA_ADDR)) acc = ACC_RD_DATA;
            else if (!cpu_wr && cpu_addr == AW'(RD_STAT_ADDR)) acc = ACC_RD_STAT;
            else if (cpu_wr && cpu_addr == AW'(WR_DATA_ADDR)) acc = ACC_WR_DATA;
            else if (cpu_wr && cpu_addr == AW'(WR_CMD_ADDR)) acc = ACC_WR_CMD;
        end
    end

endmodule

// File: rtl/vhp_byte_ram.sv
module vhp_byte_ram #(
    parameter int MEM_AW = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [BYTE_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];

    // R2: a write is visible at its address on the following cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> store_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/vhp_cmd_seq.sv
module vhp_cmd_seq
    import vhp_pkg::*;
#(
    parameter int PTR_W    = 14,
    parameter int MEM_AW   = 12,
    parameter int BYTE_W   = 8,
    parameter int NUM_REGS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  acc_e                         acc,
    input  logic                         fire,
    input  logic [BYTE_W-1:0]            wbyte,
    input  logic [BYTE_W-1:0]            mem_rdata,
    output logic [MEM_AW-1:0]            mem_raddr,
    output logic                         mem_we,
    output logic [MEM_AW-1:0]            mem_waddr,
    output logic [BYTE_W-1:0]            mem_wdata,
    output logic                         mem_touch,
    output logic [BYTE_W-1:0]            prefetch,
    output logic [NUM_REGS*BYTE_W-1:0]   regs_flat
);

    localparam int HI_W  = PTR_W - BYTE_W;
    localparam int SEL_W = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    typedef struct packed {
        logic                       phase;
        logic [BYTE_W-1:0]          latch;
        logic [PTR_W-1:0]           ptr;
        logic [BYTE_W-1:0]          pre;
        logic [NUM_REGS*BYTE_W-1:0] regs;
    } seq_t;

    seq_t s_d, s_q;

    logic [PTR_W-1:0] new_addr;
    logic             second_byte;
    cmd_op_e          op;

    assign new_addr    = {wbyte[HI_W-1:0], s_q.latch};
    assign second_byte = (acc == ACC_WR_CMD) && s_q.phase;
    assign op          = cmd_op_e'(wbyte[BYTE_W-1:BYTE_W-2]);

    assign mem_touch = (acc == ACC_RD_DATA) || (acc == ACC_WR_DATA)
                     || (second_byte && op == OP_SET_RD);

    always_comb begin
        mem_raddr = s_q.ptr[MEM_AW-1:0];
        if (fire && second_byte && op == OP_SET_RD) mem_raddr = new_addr[MEM_AW-1:0];
    end

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = s_q.ptr[MEM_AW-1:0];
        mem_wdata = wbyte;
        if (fire) begin
            unique case (acc)
                ACC_RD_DATA: begin
                    s_d.pre = mem_rdata;
                    s_d.ptr = s_q.ptr + PTR_ONE;
                end
                ACC_WR_DATA: begin
                    mem_we  = 1'b1;
                    s_d.ptr = s_q.ptr + PTR_ONE;
                end
                ACC_RD_STAT: s_d.phase = 1'b0;
                ACC_WR_CMD: begin
                    if (!s_q.phase) begin
                        s_d.phase = 1'b1;
                        s_d.latch = wbyte;
                    end else begin
                        s_d.phase = 1'b0;
                        unique case (op)
                            OP_SET_RD: begin
                                s_d.pre = mem_rdata;
                                s_d.ptr = new_addr + PTR_ONE;
                            end
                            OP_SET_WR: s_d.ptr = new_addr;
                            OP_REG_WR: s_d.regs[wbyte[SEL_W-1:0]*BYTE_W +: BYTE_W] = s_q.latch;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prefetch  = s_q.pre;
    assign regs_flat = s_q.regs;

    // R2 / R3: every accepted data access moves the pointer by exactly one
    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (acc == ACC_RD_DATA || acc == ACC_WR_DATA))
        |=> s_q.ptr == $past(s_q.ptr) + PTR_ONE);

    // R4: a register write leaves the pointer alone
    a_r4_reg_write_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && second_byte && op == OP_REG_WR) |=> $stable(s_q.ptr));

    // R5: a status read restarts the byte pairing
    a_r5_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && acc == ACC_RD_STAT) |=> !s_q.phase);

    // R10: the reserved operation is inert and closes the pair
    a_r10_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && second_byte && op == OP_NONE)
        |=> ($stable(s_q.ptr) && $stable(s_q.regs) && !s_q.phase));

    // R7: nothing moves while no access is accepted
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(s_q.ptr) && $stable(s_q.pre) && $stable(s_q.phase)));

endmodule

// File: rtl/vhp_frame_status.sv
module vhp_frame_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic stat_rd,
    output logic flag,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end)    st_d.flag = 1'b1;
        else if (stat_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag;

    // R6: a frame pulse always leaves the flag set, even against a status read
    a_r6_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> flag);

    // R5: a status read alone clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !frame_end) |=> !irq);

endmodule

// File: rtl/vhp_host_port.sv
module vhp_host_port
    import vhp_pkg::*;
#(
    parameter int          PTR_W        = 14,
    parameter int          MEM_AW       = 12,
    parameter int          NUM_REGS     = 8,
    parameter logic [15:0] RD_DATA_ADDR = 16'h8800,
    parameter logic [15:0] RD_STAT_ADDR = 16'h8802,
    parameter logic [15:0] WR_DATA_ADDR = 16'h8C00,
    parameter logic [15:0] WR_CMD_ADDR  = 16'h8C02
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic        cpu_ready,
    input  logic        engine_busy,
    input  logic        frame_end,
    output logic        irq,
    output logic [63:0] ctrl_regs
);

    localparam int BYTE_W = 8;
    localparam int BUS_W  = 2 * BYTE_W;

    acc_e              acc;
    logic              fire;
    logic              mem_touch;
    logic [BYTE_W-1:0] wbyte;
    logic              unused_low_lane;
    logic [MEM_AW-1:0] mem_raddr, mem_waddr;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;
    logic [BYTE_W-1:0] prefetch;
    logic              flag;
    logic [BYTE_W-1:0] rbyte;

    assign wbyte           = cpu_wdata[BUS_W-1:BYTE_W];
    assign unused_low_lane = ^cpu_wdata[BYTE_W-1:0];

    vhp_port_decode #(
        .AW(BUS_W),
        .RD_DATA_ADDR(RD_DATA_ADDR),
        .RD_STAT_ADDR(RD_STAT_ADDR),
        .WR_DATA_ADDR(WR_DATA_ADDR),
        .WR_CMD_ADDR(WR_CMD_ADDR)
    ) u_decode (
        .cpu_req(cpu_req),
        .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr),
        .acc(acc)
    );

    assign cpu_ready = !(mem_touch && engine_busy);
    assign fire      = (acc != ACC_IDLE) && cpu_ready;

    vhp_cmd_seq #(
        .PTR_W(PTR_W),
        .MEM_AW(MEM_AW),
        .BYTE_W(BYTE_W),
        .NUM_REGS(NUM_REGS)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .acc(acc),
        .fire(fire),
        .wbyte(wbyte),
        .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr),
        .mem_we(mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata),
        .mem_touch(mem_touch),
        .prefetch(prefetch),
        .regs_flat(ctrl_regs)
    );

    vhp_byte_ram #(
        .MEM_AW(MEM_AW),
        .BYTE_W(BYTE_W)
    ) u_ram (
        .clk(clk),
        .rst_n(rst_n),
        .we(mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    vhp_frame_status u_status (
        .clk(clk),
        .rst_n(rst_n),
        .frame_end(frame_end),
        .stat_rd(fire && acc == ACC_RD_STAT),
        .flag(flag),
        .irq(irq)
    );

    always_comb begin
        rbyte = '0;
        if (acc == ACC_RD_DATA)      rbyte = prefetch;
        else if (acc == ACC_RD_STAT) rbyte = {flag, {(BYTE_W-1){1'b0}}};
    end

    assign cpu_rdata = {rbyte, {BYTE_W{1'b0}}};

    // R7: a stall is only ever caused by the engine owning memory
    a_r7_stall_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> engine_busy);

    // R8: the low byte lane of read data is never driven
    a_r8_low_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[BYTE_W-1:0] == '0);

endmodule

// File: tb/vhp_host_port_test.sv
module vhp_host_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_SIZE   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        engine_busy = 1'b0;
    logic        frame_end = 1'b0;
    logic        irq;
    logic [63:0] ctrl_regs;

    vhp_host_port uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .engine_busy(engine_busy), .frame_end(frame_end),
        .irq(irq), .ctrl_regs(ctrl_regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit monitor_on = 0;

    // reference model state
    int       m_ptr;
    bit       m_phase;
    bit [7:0] m_latch, m_pre;
    bit [7:0] m_regs [8];
    bit       m_flag;
    bit [7:0] m_mem [MEM_SIZE];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [63:0] model_regs();
        bit [63:0] v;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = m_regs[k];
        return v;
    endfunction

    // every clock: interrupt line and configuration bytes follow the model (R4, R6, R10)
    always @(negedge clk) begin
        if (monitor_on) begin
            chk(irq == m_flag, "R6 irq", irq, m_flag);
            chk(ctrl_regs == model_regs(), "R4 ctrl_regs", ctrl_regs, model_regs());
        end
    end

    // one bus access; busy_n cycles of engine_busy, fe raises frame_end in the accepting cycle
    task automatic op(input logic [15:0] a, input bit w, input bit [7:0] b,
                      input int busy_n, input bit fe, input string req);
        bit rd_data, rd_stat, wr_data, wr_cmd, macc;
        bit [7:0] exp_r;
        int addr;
        rd_data = !w && a == 16'h8800;
        rd_stat = !w && a == 16'h8802;
        wr_data =  w && a == 16'h8C00;
        wr_cmd  =  w && a == 16'h8C02;
        macc = rd_data || wr_data || (wr_cmd && m_phase && b[7:6] == 2'b00);
        exp_r = rd_data ? m_pre : (rd_stat ? {m_flag, 7'b0} : 8'h00);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_wr = w; cpu_wdata = {b, 8'h5C};
        engine_busy = (busy_n > 0);
        frame_end = fe;
        #1;
        if (busy_n > 0 && macc) begin
            for (int i = 0; i < busy_n; i++) begin
                chk(cpu_ready == 1'b0, "R7 stall while busy", cpu_ready, 0);
                @(negedge clk);
            end
            engine_busy = 1'b0;
            #1;
            chk(cpu_ready == 1'b1, "R7 release after busy", cpu_ready, 1);
        end else if (busy_n > 0) begin
            chk(cpu_ready == 1'b1, "R7 no stall for non-memory access", cpu_ready, 1);
        end
        chk(cpu_rdata == {exp_r, 8'h00}, req, cpu_rdata, {exp_r, 8'h00});
        @(posedge clk);
        #1;
        // model update
        if (rd_data) begin
            m_pre = m_mem[m_ptr % MEM_SIZE];
            m_ptr = (m_ptr + 1) % 16384;
        end else if (wr_data) begin
            m_mem[m_ptr % MEM_SIZE] = b;
            m_ptr = (m_ptr + 1) % 16384;
        end else if (rd_stat) begin
            m_phase = 0;
        end else if (wr_cmd) begin
            if (!m_phase) begin
                m_phase = 1; m_latch = b;
            end else begin
                m_phase = 0;
                addr = {b[5:0], m_latch};
                case (b[7:6])
                    2'b00: begin m_pre = m_mem[addr % MEM_SIZE]; m_ptr = (addr + 1) % 16384; end
                    2'b01: m_ptr = addr;
                    2'b10: m_regs[b[2:0]] = m_latch;
                    default: ;
                endcase
            end
        end
        if (fe) m_flag = 1;
        else if (rd_stat) m_flag = 0;
        cpu_req = 1'b0; engine_busy = 1'b0; frame_end = 1'b0;
    endtask

    task automatic cmd(input bit [7:0] b, input string req);
        op(16'h8C02, 1'b1, b, 0, 1'b0, req);
    endtask

    task automatic set_addr(input int a, input bit for_write, input string req);
        cmd(a[7:0], req);
        cmd({1'b0, for_write, a[13:8]}, req);
    endtask

    task automatic rd(input string req);
        op(16'h8800, 1'b0, 8'h00, 0, 1'b0, req);
    endtask

    task automatic wrd(input bit [7:0] b, input string req);
        op(16'h8C00, 1'b1, b, 0, 1'b0, req);
    endtask

    task automatic stat(input bit fe, input string req);
        op(16'h8802, 1'b0, 8'h00, 0, fe, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        m_ptr = 0; m_phase = 0; m_latch = 0; m_pre = 0; m_flag = 0;
        for (int k = 0; k < 8; k++) m_regs[k] = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(ctrl_regs == 64'h0, "R1 ctrl_regs after reset", ctrl_regs, 0);
        chk(cpu_ready == 1'b1, "R1 ready after reset", cpu_ready, 1);
        monitor_on = 1;
        stat(1'b0, "R1 status after reset");

        // R2 fill memory through auto-increment writes, low lane carries junk (R8)
        set_addr(0, 1'b1, "R2 set write address");
        for (int i = 0; i < MEM_SIZE; i++) wrd(8'((i * 7) + 3), "R2 fill write");

        // R3 read back from a set-read address
        set_addr(16'h0100, 1'b0, "R3 set read address");
        for (int i = 0; i < 4; i++) rd("R3 sequential read");

        // R2 overwrite and read back
        set_addr(16'h0200, 1'b1, "R2 set write address");
        wrd(8'hA5, "R2 write"); wrd(8'h5A, "R2 write");
        set_addr(16'h0200, 1'b0, "R3 set read address");
        rd("R3 read back written byte"); rd("R3 read back written byte");

        // R4 register writes, pointer untouched
        for (int k = 0; k < 8; k++) begin
            cmd(8'(8'h11 * (k + 1)), "R4 reg value byte");
            cmd(8'h80 | 8'(k), "R4 reg select byte");
        end
        rd("R4 pointer unchanged by register write");

        // R10 reserved operation
        cmd(8'h55, "R10 first byte");
        cmd(8'hC7, "R10 reserved op");
        rd("R10 pointer unchanged by reserved op");
        set_addr(16'h0300, 1'b0, "R10 pairing restarted");
        rd("R10 read after reserved op");

        // R5 status read resets phase
        cmd(8'h12, "R5 dangling first byte");
        stat(1'b0, "R5 status read");
        set_addr(16'h0040, 1'b0, "R5 pair after status");
        rd("R5 read at paired address");

        // R6 frame pulse, irq, status clear
        @(negedge clk); frame_end = 1'b1;
        @(posedge clk); #1 m_flag = 1; frame_end = 1'b0;
        repeat (2) @(posedge clk);
        stat(1'b0, "R5 status shows flag");
        stat(1'b0, "R5 flag cleared by read");

        // R6 collisions: status read and frame pulse together
        stat(1'b1, "R6 collide with flag clear");
        stat(1'b1, "R6 collide with flag set");
        stat(1'b0, "R6 flag survived collision");

        // R7 busy stalls memory accesses only
        set_addr(16'h0500, 1'b1, "R7 set write");
        op(16'h8C00, 1'b1, 8'h3C, 3, 1'b0, "R7 stalled write");
        cmd(8'h00, "R7 first byte");
        op(16'h8C02, 1'b1, 8'h05, 4, 1'b0, "R7 stalled set-read");
        op(16'h8800, 1'b0, 8'h00, 2, 1'b0, "R7 stalled read");
        op(16'h8802, 1'b0, 8'h00, 2, 1'b0, "R7 status while busy");
        cmd(8'h9E, "R7 reg value");
        op(16'h8C02, 1'b1, 8'h86, 2, 1'b0, "R7 reg write while busy");
        rd("R7 read after busy phases");

        // R9 pointer wrap
        set_addr(16'h3FFF, 1'b1, "R9 set write top");
        wrd(8'hEE, "R9 write top"); wrd(8'hDD, "R9 write wrapped");
        set_addr(16'h3FFF, 1'b0, "R9 set read top");
        rd("R9 read top"); rd("R9 read wrapped");

        // R11 foreign addresses and wrong directions
        op(16'h8C04, 1'b1, 8'h40, 0, 1'b0, "R11 foreign write");
        op(16'h8804, 1'b0, 8'h00, 0, 1'b0, "R11 foreign read");
        op(16'h8800, 1'b1, 8'h77, 0, 1'b0, "R11 write to read port");
        op(16'h8C00, 1'b0, 8'h00, 0, 1'b0, "R11 read of write port");
        rd("R11 data stream undisturbed");
        rd("R8 data stream undisturbed");

        repeat (3) @(posedge clk);
        monitor_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule